// File: doc/BRIEF.md
# Instruction T-State Timing Sequencer

This block produces the timing frame for a small 8-bit processor core. A divide-by-two stage groups each pair of input clocks into one T-state. A counter then numbers the T-states of the current instruction. The instruction ends after a number of T-states that depends on a class code. The opcode decoder supplies that code from outside the block. The sequencer has no datapath and drives no bus. It only tells the rest of the core where it stands inside an instruction: the T-state number, a strobe on the first clock of every T-state, a one-clock pulse at the end of the instruction and a one-clock pulse when the next fetch begins.

The decoder must present the class code by the end of the third T-state, when fetch is complete. The sequencer captures the code on the clock edge that closes that T-state and keeps it until the instruction ends. The code may therefore change at any other time without effect. Register and ALU operations, and untaken conditional branches, run for the minimum of 5 T-states. Operations with a memory operand run for 8, and taken jumps or calls run for 11.

Top module: `tseq_timing`

## Requirements
- R1: Each T-state lasts exactly two clocks. `tstrobe_o` is high on the first of the two clocks and low on the second.
- R2: `tstate_o` starts at 1 in each instruction and rises by one after the second clock of every T-state except the last.
- R3: Class code 0 (register or ALU operation) gives an instruction of 5 T-states.
- R4: Class code 1 (memory operand) gives an instruction of 8 T-states.
- R5: Class code 2 (taken jump or call) gives an instruction of 11 T-states.
- R6: Class code 3 (untaken conditional jump or call) gives an instruction of 5 T-states.
- R7: Class codes 4 to 7 are undefined and give an instruction of 5 T-states.
- R8: The block samples the class code on the clock edge that ends the second clock of T-state 3. Values present on `class_i` before or after that edge have no effect on the instruction length.
- R9: `instr_end_o` is high for exactly one clock, on the second clock of the final T-state, and is low at all other times.
- R10: On the clock after `instr_end_o`, `tstate_o` is 1 and `fetch_start_o` is high. `fetch_start_o` is high only on the first clock of T-state 1.
- R11: While `rst_n` is low, and on the first clock after it is released, the outputs show the first clock of T-state 1: `tstate_o`=1, `tstrobe_o`=1, `fetch_start_o`=1, `instr_end_o`=0. Reset asserts asynchronously and can interrupt an instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock; two clocks make one T-state |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| class_i | input | 3 | Instruction class code from the decoder |
| tstate_o | output | 4 | Current T-state number, starting at 1 |
| tstrobe_o | output | 1 | High on the first clock of each T-state |
| instr_end_o | output | 1 | One-clock pulse on the last clock of an instruction |
| fetch_start_o | output | 1 | One-clock pulse on the first clock of an instruction |

## Verification
The assertions check on every cycle that the strobe alternates, that the T-state number holds across the pair of clocks and steps by one between pairs, that an end pulse only appears on a second clock at one of the three legal lengths, and that fetch start always follows an end pulse. Only the bench scenarios can show that a particular class code produces its particular length. The same applies to the capture edge ending T-state 3: the bench moves the class code just before and just after that edge. Reset in the middle of an instruction is also shown only by the bench scenarios.

// File: rtl/tseq_pkg.sv
package tseq_pkg;

  // Class codes driven by the decoder; any other value runs as the minimum length.
  typedef enum logic [2:0] {
    CLS_REG  = 3'd0,
    CLS_MEM  = 3'd1,
    CLS_JUMP = 3'd2,
    CLS_SKIP = 3'd3
  } instr_class_e;

  localparam int unsigned CLASS_W = 3;

  // Pick the instruction length in T-states for a class code.
  function automatic int unsigned len_for_class(
    input logic [CLASS_W-1:0] code,
    input int unsigned        len_short,
    input int unsigned        len_mem,
    input int unsigned        len_jump
  );
    int unsigned n;
    case (code)
      CLS_MEM:  n = len_mem;
      CLS_JUMP: n = len_jump;
      default:  n = len_short;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/tseq_phase.sv
// Two-phase divider: phase 0 is the first clock of a T-state, phase 1 the second.
module tseq_phase (
  input  logic clk,
  input  logic rst_n,
  input  logic run_en,
  output logic second_o
);

  logic phase_q;
  logic phase_d;

  always_comb begin
    phase_d = phase_q;
    if (run_en) begin
      phase_d = ~phase_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= 1'b0;
    end else begin
      phase_q <= phase_d;
    end
  end

  assign second_o = phase_q;

endmodule

// File: rtl/tseq_len.sv
// Class capture: holds the length of the running instruction in T-states.
module tseq_len
  import tseq_pkg::*;
#(
  parameter int unsigned LEN_SHORT = 5,
  parameter int unsigned LEN_MEM   = 8,
  parameter int unsigned LEN_JUMP  = 11,
  parameter int unsigned TS_W      = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cap_en,
  input  logic [CLASS_W-1:0] class_i,
  output logic [TS_W-1:0]    len_o
);

  logic [TS_W-1:0] len_q;
  logic [TS_W-1:0] len_d;
  logic [TS_W-1:0] len_dec;

  always_comb begin
    len_dec = TS_W'(len_for_class(class_i, LEN_SHORT, LEN_MEM, LEN_JUMP));
  end

  always_comb begin
    len_d = len_q;
    if (cap_en) begin
      len_d = len_dec;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q <= TS_W'(LEN_SHORT);
    end else begin
      len_q <= len_d;
    end
  end

  assign len_o = len_q;

endmodule

// File: rtl/tseq_count.sv
// T-state counter: steps on the second clock of each T-state, wraps to 1 at the length.
module tseq_count #(
  parameter int unsigned TS_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            step_en,
  input  logic [TS_W-1:0] len_i,
  output logic [TS_W-1:0] tstate_o,
  output logic            last_o
);

  localparam logic [TS_W-1:0] TS_FIRST = TS_W'(1);

  logic [TS_W-1:0] ts_q;
  logic [TS_W-1:0] ts_d;
  logic            at_last;

  assign at_last = (ts_q >= len_i);

  always_comb begin
    ts_d = ts_q;
    if (step_en) begin
      if (at_last) begin
        ts_d = TS_FIRST;
      end else begin
        ts_d = ts_q + TS_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ts_q <= TS_FIRST;
    end else begin
      ts_q <= ts_d;
    end
  end

  assign tstate_o = ts_q;
  assign last_o   = at_last;

endmodule

// File: rtl/tseq_timing.sv
module tseq_timing
  import tseq_pkg::*;
#(
  parameter int unsigned LEN_SHORT  = 5,
  parameter int unsigned LEN_MEM    = 8,
  parameter int unsigned LEN_JUMP   = 11,
  parameter int unsigned SAMPLE_TS  = 3,
  localparam int unsigned LEN_MAX   = (LEN_JUMP > LEN_MEM) ? LEN_JUMP : LEN_MEM,
  localparam int unsigned TS_W      = $clog2(LEN_MAX + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [CLASS_W-1:0] class_i,
  output logic [TS_W-1:0]    tstate_o,
  output logic               tstrobe_o,
  output logic               instr_end_o,
  output logic               fetch_start_o
);

  logic            second_clk;
  logic            step_en;
  logic            cap_en;
  logic            last_ts;
  logic [TS_W-1:0] len_cur;
  logic [TS_W-1:0] ts_cur;

  tseq_phase u_phase (
    .clk      (clk),
    .rst_n    (rst_n),
    .run_en   (1'b1),
    .second_o (second_clk)
  );

  assign step_en = second_clk;
  assign cap_en  = second_clk && (ts_cur == TS_W'(SAMPLE_TS));

  tseq_len #(
    .LEN_SHORT (LEN_SHORT),
    .LEN_MEM   (LEN_MEM),
    .LEN_JUMP  (LEN_JUMP),
    .TS_W      (TS_W)
  ) u_len (
    .clk     (clk),
    .rst_n   (rst_n),
    .cap_en  (cap_en),
    .class_i (class_i),
    .len_o   (len_cur)
  );

  tseq_count #(
    .TS_W (TS_W)
  ) u_count (
    .clk      (clk),
    .rst_n    (rst_n),
    .step_en  (step_en),
    .len_i    (len_cur),
    .tstate_o (ts_cur),
    .last_o   (last_ts)
  );

  assign tstate_o      = ts_cur;
  assign tstrobe_o     = ~second_clk;
  assign instr_end_o   = second_clk && last_ts;
  assign fetch_start_o = ~second_clk && (ts_cur == TS_W'(1));

endmodule

// File: rtl/tseq_timing_chk.sv
module tseq_timing_chk #(
  parameter int unsigned LEN_SHORT = 5,
  parameter int unsigned LEN_MEM   = 8,
  parameter int unsigned LEN_JUMP  = 11,
  parameter int unsigned TS_W      = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic [TS_W-1:0] tstate_o,
  input logic            tstrobe_o,
  input logic            instr_end_o,
  input logic            fetch_start_o
);

  a_r1_strobe_falls: assert property (@(posedge clk) disable iff (!rst_n)
    tstrobe_o |=> !tstrobe_o);

  a_r1_strobe_rises: assert property (@(posedge clk) disable iff (!rst_n)
    !tstrobe_o |=> tstrobe_o);

  a_r1_tstate_held: assert property (@(posedge clk) disable iff (!rst_n)
    tstrobe_o |=> $stable(tstate_o));

  a_r2_tstate_steps: assert property (@(posedge clk) disable iff (!rst_n)
    (!tstrobe_o && !instr_end_o) |=> (tstate_o == $past(tstate_o) + TS_W'(1)));

  a_r2_tstate_range: assert property (@(posedge clk) disable iff (!rst_n)
    (tstate_o >= TS_W'(1)) && (tstate_o <= TS_W'(LEN_JUMP)));

  a_r9_end_second_clk: assert property (@(posedge clk) disable iff (!rst_n)
    instr_end_o |-> !tstrobe_o);

  a_r9_end_legal_len: assert property (@(posedge clk) disable iff (!rst_n)
    instr_end_o |-> ((tstate_o == TS_W'(LEN_SHORT)) || (tstate_o == TS_W'(LEN_MEM)) ||
                     (tstate_o == TS_W'(LEN_JUMP))));

  a_r10_fetch_after_end: assert property (@(posedge clk) disable iff (!rst_n)
    instr_end_o |=> (fetch_start_o && (tstate_o == TS_W'(1))));

  a_r10_fetch_first_clk: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_start_o |-> (tstrobe_o && (tstate_o == TS_W'(1))));

endmodule

bind tseq_timing tseq_timing_chk #(
  .LEN_SHORT (LEN_SHORT),
  .LEN_MEM   (LEN_MEM),
  .LEN_JUMP  (LEN_JUMP),
  .TS_W      (TS_W)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .tstate_o      (tstate_o),
  .tstrobe_o     (tstrobe_o),
  .instr_end_o   (instr_end_o),
  .fetch_start_o (fetch_start_o)
);

// File: tb/tseq_timing_bench.sv
`timescale 1ns/1ps
module tseq_timing_bench;

  logic       clk;
  logic       rst_n;
  logic [2:0] class_i;
  logic [3:0] tstate_o;
  logic       tstrobe_o;
  logic       instr_end_o;
  logic       fetch_start_o;

  int total;
  int bad;
  bit done;

  tseq_timing u_tseq_timing (
    .clk           (clk),
    .rst_n         (rst_n),
    .class_i       (class_i),
    .tstate_o      (tstate_o),
    .tstrobe_o     (tstrobe_o),
    .instr_end_o   (instr_end_o),
    .fetch_start_o (fetch_start_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic int exp_len(input logic [2:0] c);
    case (c)
      3'd1:    return 8;   // R4
      3'd2:    return 11;  // R5
      default: return 5;   // R3, R6, R7
    endcase
  endfunction

  function automatic string len_tag(input logic [2:0] c);
    case (c)
      3'd0:    return "R3";
      3'd1:    return "R4";
      3'd2:    return "R5";
      3'd3:    return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Called at a falling edge where the design should be on the first clock of T-state 1.
  // pre is driven until just before the capture edge, cls across it, post after it.
  task automatic run_instr(input logic [2:0] cls, input logic [2:0] pre, input logic [2:0] post);
    int n;
    n = exp_len(cls);
    class_i = pre;
    for (int t = 1; t <= n; t++) begin
      for (int ph = 0; ph < 2; ph++) begin
        check("R2", int'(tstate_o), t);
        check("R1", int'(tstrobe_o), (ph == 0) ? 1 : 0);
        check((t == n) ? len_tag(cls) : "R9", int'(instr_end_o),
              (ph == 1 && t == n) ? 1 : 0);
        check("R10", int'(fetch_start_o), (ph == 0 && t == 1) ? 1 : 0);
        if (t == 3 && ph == 0) class_i = cls;   // R8: present across the capture edge
        if (t == 4 && ph == 0) class_i = post;  // R8: later change ignored
        @(negedge clk);
      end
    end
  endtask

  task automatic check_reset_state();
    check("R11", int'(tstate_o), 1);
    check("R11", int'(tstrobe_o), 1);
    check("R11", int'(fetch_start_o), 1);
    check("R11", int'(instr_end_o), 0);
  endtask

  initial begin
    #200000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [2:0] c;
    total = 0;
    bad = 0;
    done = 1'b0;
    rst_n = 1'b0;
    class_i = 3'd0;
    repeat (3) @(negedge clk);
    check_reset_state();  // R11 during reset
    rst_n = 1'b1;         // R11: first clock after release is T1 first clock
    check_reset_state();

    // Directed: every class code held steady (R3..R7)
    for (int k = 0; k < 8; k++) begin
      run_instr(3'(k), 3'(k), 3'(k));
    end

    // R8: class changes before and after the capture edge
    run_instr(3'd2, 3'd0, 3'd0);
    run_instr(3'd0, 3'd2, 3'd1);
    run_instr(3'd1, 3'd5, 3'd2);
    run_instr(3'd3, 3'd1, 3'd2);

    // R11: reset in the middle of a long instruction
    class_i = 3'd2;
    repeat (9) @(negedge clk);
    rst_n = 1'b0;
    #1;
    check_reset_state();
    @(negedge clk);
    check_reset_state();
    rst_n = 1'b1;
    check_reset_state();
    run_instr(3'd1, 3'd1, 3'd1);

    // Random sequence with a fixed seed
    void'($urandom(32'd4099));
    for (int k = 0; k < 60; k++) begin
      c = 3'($urandom % 8);
      if (k % 4 == 0) begin
        run_instr(c, 3'($urandom % 8), 3'($urandom % 8));
      end else begin
        run_instr(c, c, c);
      end
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule